// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block collects 96 level-sensitive interrupt lines, grouped into three banks of 32, and turns them into one request line for a processor. Each source has a mask bit, and software changes the mask bits through a small register bus. The bus has an address, a write enable, write data and combinational read data. There is no read-modify-write: each bank has one register that sets mask bits and another that clears them. A bank's current mask can be read back.

The controller looks for a source that is pending and unmasked, and the lowest-numbered one wins. It latches that source's number, raises the request, and holds both until software writes the acknowledge bit in the control register. After an acknowledge the controller can pick the next source on the following edge. Inputs are level-sensitive, so a source that is still high is picked again.

A soft reset, requested through the configuration register, puts the controller back in its power-up state for a fixed number of cycles. During that interval the status register shows that the reset is not yet done.

Top module: `bkirq_ctrl`

## Requirements
- R1: After the hardware reset is released, `irq_o` is 0 and `irq_id_o` is 0. Every mask bit is 1. Status bit 0 at offset 0x14 reads 1.
- R2: Offset 0x00 reads REV_MAJOR in bits 7:4 and REV_MINOR in bits 3:0. All higher bits read 0.
- R3: Writing to offset 0x8C + 0x20*b sets bank b's mask bits wherever the write data has a 1. Bits written as 0 keep their value.
- R4: Writing to offset 0x88 + 0x20*b clears bank b's mask bits wherever the write data has a 1. Bits written as 0 keep their value.
- R5: Offset 0x84 + 0x20*b reads bank b's mask. Source n uses bank n/32, bit n mod 32.
- R6: While no request is held, the lowest-numbered source that is high and unmasked is latched into `irq_id_o` on the next clock edge, and `irq_o` goes to 1 at the same time.
- R7: While `irq_o` is 1, `irq_id_o` does not change, even if other sources become pending, including lower-numbered ones.
- R8: A write with bit 0 set to offset 0x48 drops `irq_o` on that edge. A write to 0x48 with bit 0 clear has no effect. If a source is still pending after the acknowledge, a request is raised again on the following edge.
- R9: A masked source never causes `irq_o` to go high.
- R10: A write with bit 1 set to offset 0x10 starts a soft reset lasting SRST_CYCLES cycles. During that time status bit 0 reads 0, bit 1 of offset 0x10 reads 1, and `irq_o` is 0. When the soft reset ends, status bit 0 reads 1 and every mask bit is 1.
- R11: Reading the write-only control offset 0x48, or any unmapped offset, returns 0.
- R12: Mask writes issued during a soft reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_BANKS*BANK_W | Level-sensitive interrupt lines, active high |
| addr_i | input | ADDR_W | Register byte offset |
| we_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |
| irq_id_o | output | $clog2(NUM_BANKS*BANK_W) | Number of the latched source |

## Verification
The bench checks that the latched number holds while higher-priority sources arrive. If the design kept re-selecting instead of latching, `irq_id_o` would change in the middle of service. The bench also checks that an acknowledge with bit 0 clear is ignored and that a source still high is picked again right after an acknowledge; an edge-triggered design would lose that source. The soft-reset window is counted cycle by cycle, and a mask write is attempted inside it, which catches a wrong interval length and masks that leak out of the window. Random mask and source patterns across all three banks exercise the bank and bit mapping and the lowest-number selection against a model kept in the bench.

// File: rtl/bkirq_pkg.sv
package bkirq_pkg;
   // Register byte offsets; the bank stride is behavioural (banks decoded by it)
   localparam int unsigned OFF_REV      = 'h00;
   localparam int unsigned OFF_CFG      = 'h10;
   localparam int unsigned OFF_STAT     = 'h14;
   localparam int unsigned OFF_CTRL     = 'h48;
   localparam int unsigned OFF_MASK_RD  = 'h84;
   localparam int unsigned OFF_MASK_CLR = 'h88;
   localparam int unsigned OFF_MASK_SET = 'h8C;
   localparam int unsigned BANK_STRIDE  = 'h20;

   localparam int unsigned CFG_SRST_BIT = 1;
   localparam int unsigned CTRL_ACK_BIT = 0;
   localparam int unsigned STAT_DONE_BIT = 0;

   function automatic int unsigned bank_off(input int unsigned base, input int unsigned bank);
      return base + bank * BANK_STRIDE;
   endfunction
endpackage

// File: rtl/bkirq_mask_bank.sv
module bkirq_mask_bank #(
   parameter int unsigned W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         force_all_i,
   input  logic         set_we_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] bits_i,
   output logic [W-1:0] mask_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          mask_o <= '1;
      else if (force_all_i) mask_o <= '1;
      else if (set_we_i)    mask_o <= mask_o | bits_i;
      else if (clr_we_i)    mask_o <= mask_o & ~bits_i;
   end
endmodule

// File: rtl/bkirq_lowest.sv
module bkirq_lowest #(
   parameter int unsigned N  = 96,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec_i,
   output logic [IW-1:0] idx_o,
   output logic          hit_o
);
   always_comb begin
      idx_o = '0;
      hit_o = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            idx_o = IW'(i);
            hit_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/bkirq_srst_seq.sv
module bkirq_srst_seq #(
   parameter int unsigned CYC = 4,
   localparam int unsigned CW = $clog2(CYC + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o
);
   if (CYC < 1) begin : g_bad_cyc
      $error("bkirq_srst_seq: CYC must be at least 1");
   end

   logic [CW-1:0] left_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_o <= 1'b0;
         left_q <= '0;
      end else if (!busy_o) begin
         if (start_i) begin
            busy_o <= 1'b1;
            left_q <= CW'(CYC - 1);
         end
      end else if (left_q == '0) begin
         busy_o <= 1'b0;
      end else begin
         left_q <= left_q - 1'b1;
      end
   end
endmodule

// File: rtl/bkirq_ctrl.sv
module bkirq_ctrl
   import bkirq_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 3,
   parameter int unsigned BANK_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SRST_CYCLES = 4,
   parameter logic [3:0]  REV_MAJOR   = 4'h2,
   parameter logic [3:0]  REV_MINOR   = 4'h1,
   localparam int unsigned NUM_SRC    = NUM_BANKS * BANK_W,
   localparam int unsigned ID_W       = $clog2(NUM_SRC)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               we_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               irq_o,
   output logic [ID_W-1:0]    irq_id_o
);
   if (DATA_W != BANK_W) begin : g_bad_width
      $error("bkirq_ctrl: DATA_W must equal BANK_W");
   end
   if (NUM_BANKS < 1 || NUM_SRC < 2) begin : g_bad_count
      $error("bkirq_ctrl: need at least one bank and two sources");
   end
   if (bank_off(OFF_MASK_SET, NUM_BANKS - 1) >= (1 << ADDR_W)) begin : g_bad_addr
      $error("bkirq_ctrl: last bank does not fit the address space");
   end

   logic                              busy;
   logic                              srst_start;
   logic                              ack_wr;
   logic [NUM_BANKS-1:0][BANK_W-1:0]  bank_mask;
   logic [NUM_SRC-1:0]                mask_flat;
   logic [NUM_SRC-1:0]                pend;
   logic [ID_W-1:0]                   win_id;
   logic                              win_hit;
   logic                              irq_q;
   logic [ID_W-1:0]                   id_q;

   assign srst_start = we_i && (addr_i == ADDR_W'(OFF_CFG)) && wdata_i[CFG_SRST_BIT] && !busy;
   assign ack_wr     = we_i && (addr_i == ADDR_W'(OFF_CTRL)) && wdata_i[CTRL_ACK_BIT];

   bkirq_srst_seq #(.CYC(SRST_CYCLES)) u_srst (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(srst_start),
      .busy_o (busy)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic set_we, clr_we;
      assign set_we = we_i && (addr_i == ADDR_W'(bank_off(OFF_MASK_SET, b)));
      assign clr_we = we_i && (addr_i == ADDR_W'(bank_off(OFF_MASK_CLR, b)));
      bkirq_mask_bank #(.W(BANK_W)) u_mask (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .force_all_i(busy || srst_start),
         .set_we_i   (set_we),
         .clr_we_i   (clr_we),
         .bits_i     (wdata_i[BANK_W-1:0]),
         .mask_o     (bank_mask[b])
      );
   end

   assign mask_flat = bank_mask;
   assign pend      = src_i & ~mask_flat;

   bkirq_lowest #(.N(NUM_SRC)) u_pick (
      .vec_i(pend),
      .idx_o(win_id),
      .hit_o(win_hit)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_q <= 1'b0;
         id_q  <= '0;
      end else if (busy || srst_start) begin
         irq_q <= 1'b0;
         id_q  <= '0;
      end else if (irq_q) begin
         if (ack_wr) begin
            irq_q <= 1'b0;
            id_q  <= '0;
         end
      end else if (win_hit) begin
         irq_q <= 1'b1;
         id_q  <= win_id;
      end
   end

   assign irq_o    = irq_q;
   assign irq_id_o = id_q;

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(OFF_REV)) begin
         rdata_o[7:0] = {REV_MAJOR, REV_MINOR};
      end else if (addr_i == ADDR_W'(OFF_CFG)) begin
         rdata_o[CFG_SRST_BIT] = busy;
      end else if (addr_i == ADDR_W'(OFF_STAT)) begin
         rdata_o[STAT_DONE_BIT] = !busy;
      end else begin
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr_i == ADDR_W'(bank_off(OFF_MASK_RD, b))) rdata_o = bank_mask[b];
         end
      end
   end
endmodule

// File: rtl/bkirq_ctrl_chk.sv
module bkirq_ctrl_chk
   import bkirq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 96,
   parameter int unsigned ADDR_W  = 8,
   localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [NUM_SRC-1:0] src_i,
   input logic [ADDR_W-1:0]  addr_i,
   input logic               we_i,
   input logic               ack_bit,
   input logic               srst_bit,
   input logic               irq_o,
   input logic [ID_W-1:0]    irq_id_o,
   input logic               busy,
   input logic [NUM_SRC-1:0] mask_flat
);
   logic               ack_w, srst_w;
   logic [NUM_SRC-1:0] pend_d;
   logic [NUM_SRC-1:0] below;

   assign ack_w  = we_i && addr_i == ADDR_W'(OFF_CTRL) && ack_bit;
   assign srst_w = we_i && addr_i == ADDR_W'(OFF_CFG) && srst_bit;
   assign below  = ~({NUM_SRC{1'b1}} << irq_id_o);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_d <= '0;
      else         pend_d <= src_i & ~mask_flat;
   end

   // R6/R9: a fresh request names a source that was pending and unmasked
   a_r9_rise_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> pend_d[irq_id_o]);

   // R6: and it is the lowest such source
   a_r6_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> ((pend_d & below) == '0));

   a_r7_id_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && !ack_w && !srst_w && !busy) |=> (irq_o && $stable(irq_id_o)));

   a_r8_ack_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && ack_w) |=> !irq_o);

   a_r10_quiet_in_srst: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy |-> !irq_o);

   a_r10_srst_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (srst_w && !busy) |=> busy);

   a_r10_masks_after_srst: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy) |-> (&mask_flat));

   always_comb begin
      a_r6_id_range: assert (!rst_ni || int'(irq_id_o) < NUM_SRC);
   end
endmodule

bind bkirq_ctrl bkirq_ctrl_chk #(
   .NUM_SRC(NUM_SRC),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .src_i    (src_i),
   .addr_i   (addr_i),
   .we_i     (we_i),
   .ack_bit  (wdata_i[0]),
   .srst_bit (wdata_i[1]),
   .irq_o    (irq_o),
   .irq_id_o (irq_id_o),
   .busy     (busy),
   .mask_flat(mask_flat)
);

// File: tb/bkirq_ctrl_tb_top.sv
module bkirq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NB   = 3;
   localparam int BW   = 32;
   localparam int NS   = NB * BW;
   localparam int SRST = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src = '0;
   logic [7:0]    addr = '0;
   logic          we = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq;
   logic [6:0]    irq_id;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [NS-1:0] m_exp;

   always #(CLK_PERIOD/2) clk = ~clk;

   bkirq_ctrl #(.NUM_BANKS(NB), .BANK_W(BW), .SRST_CYCLES(SRST),
                .REV_MAJOR(4'h2), .REV_MINOR(4'h1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .we_i(we),
      .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .irq_id_o(irq_id)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      addr = 8'(a); wdata = d; we = 1'b1;
      @(posedge clk);
      #1 we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      addr = 8'(a);
      #1 d = rdata;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic set_src(input logic [NS-1:0] v);
      @(negedge clk);
      src = v;
   endtask

   function automatic int exp_low(input logic [NS-1:0] s, input logic [NS-1:0] m);
      for (int i = 0; i < NS; i++) if (s[i] && !m[i]) return i;
      return -1;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'd1234));
      m_exp = '1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cyc(1);

      // R1 reset state
      chk("R1 irq", {31'd0, irq}, 32'd0);
      chk("R1 id", {25'd0, irq_id}, 32'd0);
      rd('h14, r); chk("R1 done", r, 32'd1);
      for (int b = 0; b < NB; b++) begin
         rd('h84 + 'h20*b, r); chk("R1 mask", r, 32'hFFFF_FFFF);
      end
      // R2 revision
      rd('h00, r); chk("R2 rev", r, 32'h0000_0021);
      // R11 write-only and unmapped
      rd('h48, r); chk("R11 ctrl", r, 32'd0);
      rd('h04, r); chk("R11 unmapped", r, 32'd0);
      rd('hF0, r); chk("R11 unmapped hi", r, 32'd0);

      // R4 / R5 clear then R3 set with zero bits untouched
      wr('h88 + 'h20, 32'h0000_F00F);
      rd('h84 + 'h20, r); chk("R4 clr", r, 32'hFFFF_0FF0);
      wr('h8C + 'h20, 32'h0000_0003);
      rd('h84 + 'h20, r); chk("R3 set", r, 32'hFFFF_0FF3);
      rd('h84, r); chk("R5 other bank", r, 32'hFFFF_FFFF);
      m_exp[63:32] = 32'hFFFF_0FF3;

      // R9 masked source stays silent: source 32 (bank1 bit0) masked
      set_src(96'd1 << 32);
      cyc(3);
      chk("R9 masked", {31'd0, irq}, 32'd0);

      // R6 source 40 (bank1 bit8) unmasked is captured
      wr('h88 + 'h20, 32'h0000_0100); m_exp[40] = 1'b0;
      set_src((96'd1 << 40) | (96'd1 << 32));
      cyc(2);
      chk("R6 irq", {31'd0, irq}, 32'd1);
      chk("R6 id", {25'd0, irq_id}, 32'd40);

      // R7 a lower-numbered source arrives: id held
      wr('h88, 32'h0000_0008); m_exp[3] = 1'b0;
      set_src((96'd1 << 40) | (96'd1 << 3));
      cyc(3);
      chk("R7 held", {25'd0, irq_id}, 32'd40);

      // R8 ack with bit0 clear is ignored
      wr('h48, 32'h0000_0002);
      chk("R8 no-ack irq", {31'd0, irq}, 32'd1);
      chk("R8 no-ack id", {25'd0, irq_id}, 32'd40);
      // R8 real ack drops, then source 3 recaptured next edge
      wr('h48, 32'h0000_0001);
      chk("R8 drop", {31'd0, irq}, 32'd0);
      cyc(1);
      chk("R8 rearm irq", {31'd0, irq}, 32'd1);
      chk("R8 rearm id", {25'd0, irq_id}, 32'd3);

      // R10 / R12 soft reset window
      wr('h10, 32'h0000_0002);
      rd('h14, r); chk("R10 busy", r, 32'd0);
      rd('h10, r); chk("R10 cfg bit", r, 32'd2);
      chk("R10 irq low", {31'd0, irq}, 32'd0);
      wr('h88, 32'hFFFF_FFFF);
      cyc(2);
      rd('h14, r); chk("R10 still busy", r, 32'd0);
      cyc(1);
      rd('h14, r); chk("R10 done", r, 32'd1);
      rd('h10, r); chk("R10 cfg clear", r, 32'd0);
      rd('h84, r); chk("R12 mask kept", r, 32'hFFFF_FFFF);
      rd('h84 + 'h20, r); chk("R10 masks set", r, 32'hFFFF_FFFF);
      cyc(2);
      chk("R10 no irq after", {31'd0, irq}, 32'd0);
      m_exp = '1;

      // Random: masks and sources across all banks, R3 R4 R5 R6
      for (int t = 0; t < 60; t++) begin
         set_src('0);
         wr('h48, 32'h1);
         for (int k = 0; k < 2; k++) begin
            int b;
            logic [31:0] v;
            b = $urandom_range(NB - 1);
            v = $urandom();
            if ($urandom_range(1) == 1) begin
               wr('h88 + 'h20*b, v);
               m_exp[b*BW +: BW] = m_exp[b*BW +: BW] & ~v;
            end else begin
               v = v & $urandom();
               wr('h8C + 'h20*b, v);
               m_exp[b*BW +: BW] = m_exp[b*BW +: BW] | v;
            end
         end
         begin
            int b;
            b = $urandom_range(NB - 1);
            rd('h84 + 'h20*b, r);
            chk("R5 rand mask", r, m_exp[b*BW +: BW]);
         end
         begin
            logic [NS-1:0] s;
            int e;
            s = {$urandom(), $urandom(), $urandom()} & {$urandom(), $urandom(), $urandom()}
                & {$urandom(), $urandom(), $urandom()};
            set_src(s);
            cyc(2);
            e = exp_low(s, m_exp);
            chk("R6 rand irq", {31'd0, irq}, (e >= 0) ? 32'd1 : 32'd0);
            if (e >= 0) chk("R6 rand id", {25'd0, irq_id}, 32'(e));
         end
      end

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule